// File: doc/BRIEF.md
# Memory protection region checker

This block decides, within one combinational path, whether a single memory access may proceed. It compares the access address against a parameterised set of programmed regions. Each region has a power-of-two size aligned to its base and can switch off eighths of itself. It also has a three-bit permission code and a no-execute flag. The winning region's permission code is judged against the access kind and the privilege level of the requester. The block produces a permit flag, its complement as a fault flag, the index of the region that decided, and that region's memory-type attribute bits passed through unchanged.

Three global controls shape the result. A master switch turns checking off. A background switch lets privileged accesses that hit no region fall through to the default map. A handler switch decides whether accesses made from high-priority fault handlers are checked or bypassed. The region settings are held elsewhere and presented as flat vectors, one slice per region. The block has no storage of its own and sits directly in the address path of a bus master.

Top module: `mpu_region_chk`

## Requirements
- R1: A region with size code S (S from 4 to 31) covers 2^(S+1) bytes, and only address bits at positions S+1 and above are compared with its base, so low base bits are ignored. A region with S below 4, or with its enable bit clear, never matches.
- R2: For S of 7 or more, the region is split into eight equal parts numbered by address bits [S:S-2]. When bit k of the region's 8-bit subregion mask is 1, part k does not match, and the decision falls to a lower-numbered region or to the no-match rule.
- R3: For S below 7 the subregion mask is ignored and the whole region matches.
- R4: When several regions match, the highest-numbered one alone decides. hit_o is 1, hit_idx_o gives its number and attr_o gives its attribute bits. With no match, hit_o, hit_idx_o and attr_o are all 0.
- R5: The access kind is encoded as 0 read, 1 write, 2 instruction fetch and 3 (treated as write). Permission code 0 denies everything. Code 1 allows privileged read and write only. Code 2 allows privileged read and write plus unprivileged read. Code 3 allows everything.
- R6: Permission code 5 allows privileged reads only. Code 6 allows reads at both levels and denies every write. Codes 4 and 7 deny everything.
- R7: An instruction fetch is judged as a read. In addition it is denied when the deciding region has its no-execute bit set.
- R8: With the master enable at 0, every access is permitted.
- R9: With checking active and no region matching, a privileged access is permitted when the background switch is 1. Every other access is denied.
- R10: When the handler flag of an access is 1 and the handler-check switch is 0, the access is permitted. When the switch is 1, such an access is checked normally.
- R11: fault_o is always the inverse of permit_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_enable_i | input | 1 | Master enable of checking |
| ctl_bg_priv_i | input | 1 | Default map for privileged accesses with no match |
| ctl_hndl_chk_i | input | 1 | Check accesses made in handler context |
| acc_addr_i | input | ADDR_W | Access address |
| acc_kind_i | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as write |
| acc_priv_i | input | 1 | Access is privileged |
| acc_hndl_i | input | 1 | Access made in hard-fault, NMI or masked-fault handler |
| rgn_base_i | input | NUM_RGN*ADDR_W | Region base addresses, region i at slice i |
| rgn_size_i | input | NUM_RGN*5 | Region size codes |
| rgn_en_i | input | NUM_RGN | Region enables |
| rgn_srd_i | input | NUM_RGN*8 | Subregion disable masks |
| rgn_xn_i | input | NUM_RGN | No-execute flags |
| rgn_ap_i | input | NUM_RGN*3 | Permission codes |
| rgn_attr_i | input | NUM_RGN*6 | Memory-type attribute bits, not interpreted |
| permit_o | output | 1 | Access allowed |
| fault_o | output | 1 | Access denied |
| hit_o | output | 1 | Some enabled region matched |
| hit_idx_o | output | IDX_W | Number of the deciding region |
| attr_o | output | 6 | Attribute bits of the deciding region |

## Verification
Directed patterns place addresses one byte inside and one byte outside a region. This separates correct mask width from off-by-one size decoding, and a misaligned base shows whether low base bits are wrongly compared. Stacked regions sharing a base, with a subregion switched off in the upper one, show whether priority and fall-through to the lower region work. A sweep of all eight permission codes across kind and privilege catches any single swapped table entry. Random configurations with addresses clustered near the region bases exercise overlap and the no-match path against a reference model built on range arithmetic rather than bit masks.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;
   localparam int SIZE_W = 5;
   localparam int AP_W   = 3;
   localparam int SRD_W  = 8;
   localparam int ATTR_W = 6;

   localparam logic [SIZE_W-1:0] MIN_SIZE     = 5'd4;
   localparam logic [SIZE_W-1:0] MIN_SUB_SIZE = 5'd7;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [AP_W-1:0] {
      AP_NONE    = 3'd0,
      AP_PRIV_RW = 3'd1,
      AP_USER_RO = 3'd2,
      AP_ALL_RW  = 3'd3,
      AP_RSV4    = 3'd4,
      AP_PRIV_RO = 3'd5,
      AP_ALL_RO  = 3'd6,
      AP_RSV7    = 3'd7
   } ap_code_e;
endpackage

// File: rtl/mpu_rgn_match.sv
module mpu_rgn_match
   import mpu_chk_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic              en_i,
   input  logic [SRD_W-1:0]  srd_i,
   output logic              hit_o
);
   logic [ADDR_W-1:0] tag_mask;
   logic [ADDR_W-1:0] sub_shift;
   logic [2:0]        sub_idx;
   logic              tag_eq;
   logic              sub_on;
   logic              size_ok;

   always_comb begin
      for (int b = 0; b < ADDR_W; b++) begin
         tag_mask[b] = (b > int'(size_i));
      end
      tag_eq    = ((addr_i ^ base_i) & tag_mask) == '0;
      sub_shift = addr_i >> (size_i - 5'd2);
      sub_idx   = sub_shift[2:0];
      sub_on    = (size_i < MIN_SUB_SIZE) || !srd_i[sub_idx];
      size_ok   = size_i >= MIN_SIZE;
      hit_o     = en_i && size_ok && tag_eq && sub_on;
   end
endmodule

// File: rtl/mpu_prio_sel.sv
module mpu_prio_sel #(
   parameter int NUM_RGN = 8,
   parameter int IDX_W   = 3
)(
   input  logic [NUM_RGN-1:0] hit_vec_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);
   generate
      if (NUM_RGN == 1) begin : g_single
         assign any_o = hit_vec_i[0];
         assign idx_o = '0;
      end else begin : g_multi
         always_comb begin
            any_o = 1'b0;
            idx_o = '0;
            for (int i = 0; i < NUM_RGN; i++) begin
               if (hit_vec_i[i]) begin
                  any_o = 1'b1;
                  idx_o = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

   always_comb begin
      // R4
      sel_is_hit_chk: assert (!any_o || hit_vec_i[idx_o]);
      // R4
      sel_is_top_chk: assert (!any_o || ((hit_vec_i >> idx_o) == NUM_RGN'(1)));
   end
endmodule

// File: rtl/mpu_perm_decode.sv
module mpu_perm_decode
   import mpu_chk_pkg::*;
(
   input  logic [AP_W-1:0] ap_i,
   input  logic [1:0]      kind_i,
   input  logic            priv_i,
   input  logic            xn_i,
   output logic            allow_o
);
   logic rd_ok;
   logic wr_ok;
   logic is_wr;
   logic is_fetch;

   always_comb begin
      is_wr    = (kind_i == ACC_WRITE) || (kind_i == ACC_RSVD);
      is_fetch = (kind_i == ACC_FETCH);
      unique case (ap_code_e'(ap_i))
         AP_PRIV_RW: begin rd_ok = priv_i; wr_ok = priv_i; end
         AP_USER_RO: begin rd_ok = 1'b1;   wr_ok = priv_i; end
         AP_ALL_RW:  begin rd_ok = 1'b1;   wr_ok = 1'b1;   end
         AP_PRIV_RO: begin rd_ok = priv_i; wr_ok = 1'b0;   end
         AP_ALL_RO:  begin rd_ok = 1'b1;   wr_ok = 1'b0;   end
         default:    begin rd_ok = 1'b0;   wr_ok = 1'b0;   end
      endcase
      allow_o = is_wr ? wr_ok : (rd_ok && !(is_fetch && xn_i));
   end

   always_comb begin
      // R6
      ro_write_chk: assert (!(is_wr && (ap_i == 3'd5 || ap_i == 3'd6)) || !allow_o);
      // R7
      xn_fetch_chk: assert (!(is_fetch && xn_i) || !allow_o);
      // R5
      none_code_chk: assert (ap_i != 3'd0 || !allow_o);
   end
endmodule

// File: rtl/mpu_region_chk.sv
module mpu_region_chk
   import mpu_chk_pkg::*;
#(
   parameter int NUM_RGN = 8,
   parameter int ADDR_W  = 32,
   localparam int IDX_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
)(
   input  logic                        ctl_enable_i,
   input  logic                        ctl_bg_priv_i,
   input  logic                        ctl_hndl_chk_i,
   input  logic [ADDR_W-1:0]           acc_addr_i,
   input  logic [1:0]                  acc_kind_i,
   input  logic                        acc_priv_i,
   input  logic                        acc_hndl_i,
   input  logic [NUM_RGN*ADDR_W-1:0]   rgn_base_i,
   input  logic [NUM_RGN*SIZE_W-1:0]   rgn_size_i,
   input  logic [NUM_RGN-1:0]          rgn_en_i,
   input  logic [NUM_RGN*SRD_W-1:0]    rgn_srd_i,
   input  logic [NUM_RGN-1:0]          rgn_xn_i,
   input  logic [NUM_RGN*AP_W-1:0]     rgn_ap_i,
   input  logic [NUM_RGN*ATTR_W-1:0]   rgn_attr_i,
   output logic                        permit_o,
   output logic                        fault_o,
   output logic                        hit_o,
   output logic [IDX_W-1:0]            hit_idx_o,
   output logic [ATTR_W-1:0]           attr_o
);
   generate
      if (NUM_RGN < 1 || NUM_RGN > 16) begin : g_bad_rgn
         $error("NUM_RGN must lie in 1..16");
      end
      if (ADDR_W < 12 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 12..32");
      end
   endgenerate

   logic [NUM_RGN-1:0] hit_vec;
   logic               any_hit;
   logic [IDX_W-1:0]   win_idx;
   logic [AP_W-1:0]    win_ap;
   logic               win_xn;
   logic [ATTR_W-1:0]  win_attr;
   logic               rgn_allow;
   logic               bypass;

   for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
      mpu_rgn_match #(.ADDR_W(ADDR_W)) u_match (
         .addr_i (acc_addr_i),
         .base_i (rgn_base_i[g*ADDR_W +: ADDR_W]),
         .size_i (rgn_size_i[g*SIZE_W +: SIZE_W]),
         .en_i   (rgn_en_i[g]),
         .srd_i  (rgn_srd_i[g*SRD_W +: SRD_W]),
         .hit_o  (hit_vec[g])
      );
   end

   mpu_prio_sel #(.NUM_RGN(NUM_RGN), .IDX_W(IDX_W)) u_sel (
      .hit_vec_i (hit_vec),
      .any_o     (any_hit),
      .idx_o     (win_idx)
   );

   always_comb begin
      win_ap   = '0;
      win_xn   = 1'b0;
      win_attr = '0;
      for (int i = 0; i < NUM_RGN; i++) begin
         if (any_hit && (win_idx == IDX_W'(i))) begin
            win_ap   = rgn_ap_i[i*AP_W +: AP_W];
            win_xn   = rgn_xn_i[i];
            win_attr = rgn_attr_i[i*ATTR_W +: ATTR_W];
         end
      end
   end

   mpu_perm_decode u_perm (
      .ap_i    (win_ap),
      .kind_i  (acc_kind_i),
      .priv_i  (acc_priv_i),
      .xn_i    (win_xn),
      .allow_o (rgn_allow)
   );

   always_comb begin
      bypass = !ctl_enable_i || (acc_hndl_i && !ctl_hndl_chk_i);
      if (bypass) begin
         permit_o = 1'b1;
      end else if (any_hit) begin
         permit_o = rgn_allow;
      end else begin
         permit_o = ctl_bg_priv_i && acc_priv_i;
      end
      fault_o   = !permit_o;
      hit_o     = any_hit;
      hit_idx_o = any_hit ? win_idx : '0;
      attr_o    = win_attr;
   end

   always_comb begin
      // R8
      off_permits_chk: assert (ctl_enable_i || permit_o);
      // R10
      hndl_bypass_chk: assert (!(acc_hndl_i && !ctl_hndl_chk_i) || permit_o);
      // R9
      nomatch_user_chk: assert (!(ctl_enable_i && !(acc_hndl_i && !ctl_hndl_chk_i)
                                  && !hit_o && !acc_priv_i) || fault_o);
      // R4
      nohit_zero_chk: assert (hit_o || (hit_idx_o == '0 && attr_o == '0));
   end
endmodule

// File: tb/mpu_region_chk_tb.sv
module mpu_region_chk_tb;
   localparam int NR = 8;
   localparam int AW = 32;
   localparam int IW = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;

   logic          c_en, c_bg, c_hc;
   logic [AW-1:0] a_addr;
   logic [1:0]    a_kind;
   logic          a_priv, a_hndl;

   logic [AW-1:0] base [NR];
   logic [4:0]    size [NR];
   logic          ren  [NR];
   logic [7:0]    srd  [NR];
   logic          xn   [NR];
   logic [2:0]    ap   [NR];
   logic [5:0]    attr [NR];

   logic [NR*AW-1:0] base_f;
   logic [NR*5-1:0]  size_f;
   logic [NR-1:0]    en_f;
   logic [NR*8-1:0]  srd_f;
   logic [NR-1:0]    xn_f;
   logic [NR*3-1:0]  ap_f;
   logic [NR*6-1:0]  attr_f;

   always_comb begin
      for (int i = 0; i < NR; i++) begin
         base_f[i*AW +: AW] = base[i];
         size_f[i*5 +: 5]   = size[i];
         en_f[i]            = ren[i];
         srd_f[i*8 +: 8]    = srd[i];
         xn_f[i]            = xn[i];
         ap_f[i*3 +: 3]     = ap[i];
         attr_f[i*6 +: 6]   = attr[i];
      end
   end

   logic          permit, fault, hit;
   logic [IW-1:0] hidx;
   logic [5:0]    hattr;

   mpu_region_chk #(.NUM_RGN(NR), .ADDR_W(AW)) u_dut (
      .ctl_enable_i   (c_en),
      .ctl_bg_priv_i  (c_bg),
      .ctl_hndl_chk_i (c_hc),
      .acc_addr_i     (a_addr),
      .acc_kind_i     (a_kind),
      .acc_priv_i     (a_priv),
      .acc_hndl_i     (a_hndl),
      .rgn_base_i     (base_f),
      .rgn_size_i     (size_f),
      .rgn_en_i       (en_f),
      .rgn_srd_i      (srd_f),
      .rgn_xn_i       (xn_f),
      .rgn_ap_i       (ap_f),
      .rgn_attr_i     (attr_f),
      .permit_o       (permit),
      .fault_o        (fault),
      .hit_o          (hit),
      .hit_idx_o      (hidx),
      .attr_o         (hattr)
   );

   // reference results
   logic          e_permit, e_hit;
   logic [IW-1:0] e_idx;
   logic [5:0]    e_attr;

   function automatic logic perm_ok(input logic [2:0] code, input logic [1:0] kind,
                                    input logic priv, input logic nx);
      logic wr;
      logic rd;
      wr = (kind == 2'd1 || kind == 2'd3);
      rd = (code == 3'd3) || (code == 3'd2) || (code == 3'd6)
           || (priv && (code == 3'd1 || code == 3'd5));
      if (wr) return (code == 3'd3) || (priv && (code == 3'd1 || code == 3'd2));
      if (kind == 2'd2 && nx) return 1'b0;
      return rd;
   endfunction

   function automatic void model();
      logic [63:0] sz, lo, a, part;
      e_hit  = 1'b0;
      e_idx  = '0;
      e_attr = '0;
      a = {32'd0, a_addr};
      for (int i = 0; i < NR; i++) begin
         if (ren[i] && size[i] >= 5'd4) begin
            sz = 64'd1 << (size[i] + 1);
            lo = {32'd0, base[i]} & ~(sz - 64'd1);
            if (a >= lo && a < lo + sz) begin
               part = (a - lo) / (sz / 64'd8);
               if (size[i] < 5'd7 || !srd[i][part[2:0]]) begin
                  e_hit  = 1'b1;
                  e_idx  = IW'(i);
                  e_attr = attr[i];
               end
            end
         end
      end
      if (!c_en || (a_hndl && !c_hc)) e_permit = 1'b1;
      else if (e_hit) e_permit = perm_ok(ap[e_idx], a_kind, a_priv, xn[e_idx]);
      else e_permit = c_bg && a_priv;
   endfunction

   task automatic clear_rgns();
      for (int i = 0; i < NR; i++) begin
         base[i] = '0; size[i] = '0; ren[i] = 1'b0; srd[i] = '0;
         xn[i] = 1'b0; ap[i] = '0; attr[i] = '0;
      end
   endtask

   task automatic set_rgn(input int i, input logic [31:0] b, input logic [4:0] s,
                          input logic [7:0] d, input logic [2:0] p, input logic x,
                          input logic [5:0] t);
      base[i] = b; size[i] = s; ren[i] = 1'b1; srd[i] = d; ap[i] = p; xn[i] = x; attr[i] = t;
   endtask

   task automatic access(input logic [31:0] ad, input logic [1:0] k,
                         input logic pv, input logic hd);
      @(negedge clk);
      a_addr = ad; a_kind = k; a_priv = pv; a_hndl = hd;
      #1;
   endtask

   task automatic chk(input string tag, input logic ep, input logic eh, input logic [IW-1:0] ei);
      n_chk++;
      if (permit !== ep || fault !== !ep || hit !== eh || hidx !== (eh ? ei : '0)) begin
         n_err++;
         $display("FAIL %s addr=%h: permit=%b fault=%b hit=%b idx=%0d expected permit=%b fault=%b hit=%b idx=%0d",
                  tag, a_addr, permit, fault, hit, hidx, ep, !ep, eh, eh ? ei : '0);
      end
   endtask

   task automatic chk_attr(input string tag, input logic [5:0] ea);
      n_chk++;
      if (hattr !== ea) begin
         n_err++;
         $display("FAIL %s attr=%h expected %h", tag, hattr, ea);
      end
   endtask

   task automatic chk_model(input string tag);
      model();
      chk(tag, e_permit, e_hit, e_idx);
      chk_attr(tag, e_attr);
   endtask

   initial begin
      #(4 * 200000);
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      clear_rgns();
      c_en = 1'b0; c_bg = 1'b0; c_hc = 1'b0;
      a_addr = '0; a_kind = 2'd0; a_priv = 1'b0; a_hndl = 1'b0;

      // idle state with checking off: R8
      access(32'h0, 2'd1, 1'b0, 1'b0);
      chk("R8", 1'b1, 1'b0, 0);
      chk("R11", 1'b1, 1'b0, 0);

      c_en = 1'b1; c_hc = 1'b1;
      // R1 bounds of a 4 KB region
      set_rgn(0, 32'h0000_1000, 5'd11, 8'h00, 3'd3, 1'b0, 6'h11);
      access(32'h0000_1FFF, 2'd0, 1'b0, 1'b0); chk("R1", 1'b1, 1'b1, 0);
      access(32'h0000_2000, 2'd0, 1'b0, 1'b0); chk("R1", 1'b0, 1'b0, 0);
      access(32'h0000_0FFF, 2'd0, 1'b0, 1'b0); chk("R1", 1'b0, 1'b0, 0);
      // R1 misaligned base bits ignored
      base[0] = 32'h0000_1800;
      access(32'h0000_1000, 2'd0, 1'b0, 1'b0); chk("R1", 1'b1, 1'b1, 0);
      // R1 reserved size never matches
      size[0] = 5'd3; base[0] = 32'h0000_1000;
      access(32'h0000_1000, 2'd0, 1'b0, 1'b0); chk("R1", 1'b0, 1'b0, 0);
      // R1 full 4 GB region
      size[0] = 5'd31; base[0] = 32'h0;
      access(32'hFFFF_FFF0, 2'd1, 1'b0, 1'b0); chk("R1", 1'b1, 1'b1, 0);
      // R1 disabled region
      ren[0] = 1'b0;
      access(32'hFFFF_FFF0, 2'd1, 1'b0, 1'b0); chk("R1", 1'b0, 1'b0, 0);

      // R2 subregions of 1 KB region (128 B parts)
      clear_rgns();
      set_rgn(0, 32'h0000_4000, 5'd9, 8'b0000_0100, 3'd3, 1'b0, 6'h01);
      access(32'h0000_4100, 2'd0, 1'b0, 1'b0); chk("R2", 1'b0, 1'b0, 0);
      access(32'h0000_4080, 2'd0, 1'b0, 1'b0); chk("R2", 1'b1, 1'b1, 0);
      access(32'h0000_43FF, 2'd0, 1'b0, 1'b0); chk("R2", 1'b1, 1'b1, 0);
      // R3 small region ignores mask
      set_rgn(1, 32'h0000_5000, 5'd6, 8'hFF, 3'd3, 1'b0, 6'h02);
      access(32'h0000_5070, 2'd0, 1'b0, 1'b0); chk("R3", 1'b1, 1'b1, 1);

      // R4 overlap: highest number wins, attributes follow
      clear_rgns();
      set_rgn(2, 32'h0000_8000, 5'd15, 8'h00, 3'd3, 1'b0, 6'h2A);
      set_rgn(5, 32'h0000_8000, 5'd9,  8'h00, 3'd0, 1'b0, 6'h15);
      access(32'h0000_8010, 2'd0, 1'b1, 1'b0); chk("R4", 1'b0, 1'b1, 5); chk_attr("R4", 6'h15);
      access(32'h0000_9000, 2'd0, 1'b1, 1'b0); chk("R4", 1'b1, 1'b1, 2); chk_attr("R4", 6'h2A);
      srd[5] = 8'h01;
      access(32'h0000_8010, 2'd0, 1'b1, 1'b0); chk("R2", 1'b1, 1'b1, 2); chk_attr("R4", 6'h2A);
      access(32'h0002_0000, 2'd0, 1'b1, 1'b0); chk("R4", 1'b0, 1'b0, 0); chk_attr("R4", 6'h00);

      // R5 R6 R7 permission sweep over whole space
      clear_rgns();
      set_rgn(3, 32'h0, 5'd31, 8'h00, 3'd0, 1'b0, 6'h3F);
      for (int c = 0; c < 8; c++) begin
         for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < 2; p++) begin
               ap[3] = 3'(c);
               access(32'h1234_5678, 2'(k), 1'(p), 1'b0);
               if (c == 5 || c == 6 || c == 4 || c == 7) chk_model("R6");
               else chk_model("R5");
            end
         end
      end
      // explicit spot values
      ap[3] = 3'd2;
      access(32'h10, 2'd1, 1'b0, 1'b0); chk("R5", 1'b0, 1'b1, 3);
      access(32'h10, 2'd0, 1'b0, 1'b0); chk("R5", 1'b1, 1'b1, 3);
      ap[3] = 3'd6;
      access(32'h10, 2'd1, 1'b1, 1'b0); chk("R6", 1'b0, 1'b1, 3);
      ap[3] = 3'd5;
      access(32'h10, 2'd0, 1'b0, 1'b0); chk("R6", 1'b0, 1'b1, 3);
      access(32'h10, 2'd0, 1'b1, 1'b0); chk("R6", 1'b1, 1'b1, 3);
      ap[3] = 3'd3; xn[3] = 1'b1;
      access(32'h10, 2'd2, 1'b1, 1'b0); chk("R7", 1'b0, 1'b1, 3);
      access(32'h10, 2'd0, 1'b1, 1'b0); chk("R7", 1'b1, 1'b1, 3);
      xn[3] = 1'b0; ap[3] = 3'd1;
      access(32'h10, 2'd2, 1'b0, 1'b0); chk("R7", 1'b0, 1'b1, 3);
      access(32'h10, 2'd2, 1'b1, 1'b0); chk("R7", 1'b1, 1'b1, 3);

      // R9 background map
      clear_rgns();
      c_bg = 1'b1;
      access(32'h7000_0000, 2'd1, 1'b1, 1'b0); chk("R9", 1'b1, 1'b0, 0);
      access(32'h7000_0000, 2'd0, 1'b0, 1'b0); chk("R9", 1'b0, 1'b0, 0);
      c_bg = 1'b0;
      access(32'h7000_0000, 2'd0, 1'b1, 1'b0); chk("R9", 1'b0, 1'b0, 0);

      // R10 handler bypass
      c_hc = 1'b0;
      access(32'h7000_0000, 2'd1, 1'b0, 1'b1); chk("R10", 1'b1, 1'b0, 0);
      access(32'h7000_0000, 2'd1, 1'b0, 1'b0); chk("R10", 1'b0, 1'b0, 0);
      c_hc = 1'b1;
      access(32'h7000_0000, 2'd1, 1'b0, 1'b1); chk("R10", 1'b0, 1'b0, 0);

      // R8 off with a denying region present
      set_rgn(0, 32'h7000_0000, 5'd12, 8'h00, 3'd0, 1'b0, 6'h05);
      c_en = 1'b0;
      access(32'h7000_0000, 2'd1, 1'b0, 1'b0); chk("R8", 1'b1, 1'b1, 0);
      c_en = 1'b1;
      access(32'h7000_0000, 2'd1, 1'b0, 1'b0); chk("R11", 1'b0, 1'b1, 0);

      // random configurations clustered near one window
      for (int it = 0; it < 3000; it++) begin
         if (it % 50 == 0) begin
            for (int i = 0; i < NR; i++) begin
               base[i] = 32'h2000_0000 | ($urandom & 32'h0001_FFFF);
               size[i] = 5'(2 + ($urandom % 15));
               ren[i]  = 1'($urandom % 4 != 0);
               srd[i]  = 8'($urandom);
               xn[i]   = 1'($urandom);
               ap[i]   = 3'($urandom);
               attr[i] = 6'($urandom);
            end
            c_en = 1'($urandom % 8 != 0);
            c_bg = 1'($urandom);
            c_hc = 1'($urandom);
         end
         access(32'h2000_0000 | ($urandom & 32'h0001_FFFF), 2'($urandom),
                1'($urandom), 1'($urandom % 6 == 0));
         chk_model("R4");
      end

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule